// File: doc/BRIEF.md
# SPI FIFO Level and Interrupt Unit

This unit sits between a serial shift engine and the host side of a serial peripheral controller. It holds two byte queues: a transmit queue that the host fills and the shift engine drains, and a receive queue that the shift engine fills and the host drains. Both queues are first-word-fall-through, so the head byte is visible on the read data port before it is popped. Each queue can be emptied on its own by a one-cycle flush pulse.

The current fill of both queues is packed into one 32-bit level word. Three event sources feed a latched status word: the receive queue reaching three quarters full, the transmit queue falling to one quarter full or less, and a transfer-done pulse from the shift engine. Every status bit is cleared by writing a 1 to it, and it is set again at once if its condition still holds. An enable word masks the latched bits, and the result is combined into a single interrupt line.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each queue holds 64 bytes and returns them in the order they were pushed, with the head byte shown before it is popped. A push into a full queue and a pop from an empty queue leave the fill and the contents unchanged.
- R2: fifo_level carries the receive fill (0 to 64) in bits [6:0] and the transmit fill in bits [22:16]. All other bits read as zero. The fill changes on the clock edge that performs the push or pop.
- R3: int_status bit 4 sets on the clock edge after an edge that begins with a receive fill of 48 or more.
- R4: int_status bit 12 sets on the clock edge after an edge that begins with a transmit fill of 16 or less. This includes the first edge after reset, when the transmit queue is empty.
- R5: A one-cycle xfer_done pulse sets int_status bit 16 on the same edge.
- R6: When clr_we is high, each 1 in clr_data clears the matching status bit on that edge. A 0 leaves its bit unchanged, and an all-ones word clears every bit whose condition no longer holds.
- R7: A status bit that is cleared while its condition still holds stays set.
- R8: irq is high when any status bit at position 4, 12 or 16 is set and the same bit of irq_en is 1. Status bits latch even when their enable bit is 0.
- R9: tx_flush and rx_flush each empty only their own queue on the next edge. A flush overrides a push or pop to the same queue in that cycle, and the next byte pushed after a flush is the next byte read.
- R10: While rst_n is low, both fills read 0, int_status reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_tx_push | input | 1 | Host writes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte written by the host |
| eng_tx_pop | input | 1 | Shift engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head byte of the transmit queue |
| eng_rx_push | input | 1 | Shift engine stores a received byte |
| eng_rx_data | input | 8 | Byte stored by the shift engine |
| host_rx_pop | input | 1 | Host takes the head receive byte |
| host_rx_data | output | 8 | Head byte of the receive queue |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| xfer_done | input | 1 | Transfer-done pulse from the shift engine |
| irq_en | input | 32 | Interrupt enable word (bits 4, 12 and 16 are used) |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | 32 | Write-1-to-clear mask for the status word |
| int_status | output | 32 | Latched event status word |
| fifo_level | output | 32 | Packed receive and transmit fills |
| tx_full | output | 1 | Transmit queue holds 64 bytes |
| tx_empty | output | 1 | Transmit queue holds no byte |
| rx_full | output | 1 | Receive queue holds 64 bytes |
| rx_empty | output | 1 | Receive queue holds no byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong pointer or fill count shows up at fifo_level on the edge after the faulty push or pop, and a swapped or lost byte shows up at the head data port as soon as that byte becomes the head. A wrong threshold comparison moves the cycle in which bit 4 or bit 12 rises, and the fill sweeps catch that to the exact cycle. A clear that fails to re-raise a held condition, or one that wipes an unrelated bit, changes int_status one edge after the clear strobe. A wrong mask shows at irq in the same cycle.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  localparam int REG_W       = 32;
  localparam int RX_HI_POS   = 4;
  localparam int TX_LO_POS   = 12;
  localparam int DONE_POS    = 16;
  localparam int RX_LVL_LSB  = 0;
  localparam int TX_LVL_LSB  = 16;
  localparam int NUM_SRC     = 3;

  // status bit position of event source i (0: rx high, 1: tx low, 2: done)
  function automatic int src_pos(input int i);
    case (i)
      0:       return RX_HI_POS;
      1:       return TX_LO_POS;
      default: return DONE_POS;
    endcase
  endfunction

  // receive side: at least three quarters of the depth in use
  function automatic logic rx_high(input int unsigned fill, input int unsigned depth);
    return (fill * 4) >= (depth * 3);
  endfunction

  // transmit side: at most one quarter of the depth in use
  function automatic logic tx_low(input int unsigned fill, input int unsigned depth);
    return (fill * 4) <= depth;
  endfunction

  // pack both fills into the level word
  function automatic logic [REG_W-1:0] pack_levels(input int unsigned rx_fill,
                                                   input int unsigned tx_fill);
    logic [REG_W-1:0] w;
    w = '0;
    w[RX_LVL_LSB +: 7] = rx_fill[6:0];
    w[TX_LVL_LSB +: 7] = tx_fill[6:0];
    return w;
  endfunction

  // mask of the status positions that carry a source
  function automatic logic [REG_W-1:0] src_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/irq_source.sv
module irq_source (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  input  logic enable,
  output logic flag,
  output logic req
);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag && !clr) || cond;
  end

  assign req = flag && enable;

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_tx_push,
  input  logic [7:0]       host_tx_data,
  input  logic             eng_tx_pop,
  output logic [7:0]       eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [7:0]       eng_rx_data,
  input  logic             host_rx_pop,
  output logic [7:0]       host_rx_data,
  input  logic             tx_flush,
  input  logic             rx_flush,
  input  logic             xfer_done,
  input  logic [REG_W-1:0] irq_en,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_data,
  output logic [REG_W-1:0] int_status,
  output logic [REG_W-1:0] fifo_level,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             irq
);

  logic [CW-1:0]      tx_count, rx_count;
  logic               rx_hi_evt, tx_lo_evt;
  logic [NUM_SRC-1:0] src_cond, src_flag, src_req;
  logic [REG_W-1:0]   unused_ctl_bits;

  byte_fifo #(.DW(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (host_tx_push),
    .wdata (host_tx_data),
    .pop   (eng_tx_pop),
    .rdata (eng_tx_data),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  byte_fifo #(.DW(8), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (eng_rx_push),
    .wdata (eng_rx_data),
    .pop   (host_rx_pop),
    .rdata (host_rx_data),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

  // named threshold events, visible to the checker
  assign rx_hi_evt = rx_high(int'(rx_count), DEPTH);
  assign tx_lo_evt = tx_low(int'(tx_count), DEPTH);
  assign src_cond  = {xfer_done, tx_lo_evt, rx_hi_evt};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int POS = src_pos(g);
    irq_source u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond   (src_cond[g]),
      .clr    (clr_we && clr_data[POS]),
      .enable (irq_en[POS]),
      .flag   (src_flag[g]),
      .req    (src_req[g])
    );
  end

  always_comb begin
    int_status = '0;
    for (int i = 0; i < NUM_SRC; i++) int_status[src_pos(i)] = src_flag[i];
  end

  assign fifo_level      = pack_levels(int'(rx_count), int'(tx_count));
  assign irq             = |src_req;
  assign unused_ctl_bits = (irq_en | clr_data) & ~src_mask();

endmodule

// File: rtl/spi_fifo_irq_checker.sv
module spi_fifo_irq_checker #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_hi_evt,
  input logic          tx_lo_evt,
  input logic          eng_rx_push,
  input logic          host_rx_pop,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic          xfer_done,
  input logic          clr_we,
  input logic [31:0]   clr_data,
  input logic [31:0]   irq_en,
  input logic [31:0]   int_status,
  input logic [31:0]   fifo_level,
  input logic          irq
);

  assert_rx_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  assert_tx_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH) && eng_rx_push && !host_rx_pop && !rx_flush)
    |=> (rx_count == CW'(DEPTH)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level[15:7] == '0) && (fifo_level[31:23] == '0));

  assert_rx_high_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hi_evt |=> int_status[4]);

  assert_tx_low_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lo_evt |=> int_status[12]);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> int_status[16]);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[16] && !xfer_done) |=> !int_status[16]);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en[4] && !irq_en[12] && !irq_en[16]) |-> !irq);

  assert_rx_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (fifo_level[6:0] == '0));

  assert_tx_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (fifo_level[22:16] == '0));

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_checker #(.DEPTH(DEPTH)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_count    (rx_count),
  .tx_count    (tx_count),
  .rx_hi_evt   (rx_hi_evt),
  .tx_lo_evt   (tx_lo_evt),
  .eng_rx_push (eng_rx_push),
  .host_rx_pop (host_rx_pop),
  .rx_flush    (rx_flush),
  .tx_flush    (tx_flush),
  .xfer_done   (xfer_done),
  .clr_we      (clr_we),
  .clr_data    (clr_data),
  .irq_en      (irq_en),
  .int_status  (int_status),
  .fifo_level  (fifo_level),
  .irq         (irq)
);

// File: tb/spi_fifo_irq_unit_bench.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_tx_push, eng_tx_pop, eng_rx_push, host_rx_pop;
  logic [7:0]  host_tx_data, eng_rx_data, eng_tx_data, host_rx_data;
  logic        tx_flush, rx_flush, xfer_done, clr_we;
  logic [31:0] irq_en, clr_data, int_status, fifo_level;
  logic        tx_full, tx_empty, rx_full, rx_empty, irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit u_spi_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .xfer_done(xfer_done),
    .irq_en(irq_en), .clr_we(clr_we), .clr_data(clr_data),
    .int_status(int_status), .fifo_level(fifo_level),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .irq(irq)
  );

  function automatic logic [31:0] lvl(input int rx, input int tx);
    return (32'(tx) << 16) | 32'(rx);
  endfunction

  function automatic logic [7:0] rx_byte(input int i);
    return 8'((i * 5 + 7) % 256);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_tx_push = 0; eng_tx_pop = 0; eng_rx_push = 0; host_rx_pop = 0;
    host_tx_data = 0; eng_rx_data = 0;
    tx_flush = 0; rx_flush = 0; xfer_done = 0; clr_we = 0;
    irq_en = 0; clr_data = 0;
    repeat (3) step();
    chk("R10 level", fifo_level, 32'h0);
    chk("R10 status", int_status, 32'h0);
    chk("R10 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    step();
    chk("R4 empty tx sets bit12", int_status, 32'h0000_1000);
    chk("R8 latched but masked", 32'(irq), 32'h0);

    clr_we = 1; clr_data = 32'hFFFF_FFFF;
    step();
    clr_we = 0; clr_data = 0;
    chk("R7 held condition re-raises", int_status, 32'h0000_1000);

    // receive fill sweep
    for (int i = 1; i <= 64; i++) begin
      eng_rx_push = 1; eng_rx_data = rx_byte(i);
      step();
      eng_rx_push = 0;
      chk("R2 rx fill", fifo_level, lvl(i, 0));
      chk("R3 rx threshold", 32'(int_status[4]), 32'((i - 1) >= 48));
    end
    step();
    chk("R3 rx full latched", 32'(int_status[4]), 32'h1);
    chk("R1 rx full flag", 32'(rx_full), 32'h1);
    eng_rx_push = 1; eng_rx_data = 8'hEE;
    step();
    eng_rx_push = 0;
    chk("R1 push into full dropped", fifo_level, lvl(64, 0));

    irq_en = 32'h0000_0010;
    #1;
    chk("R8 enabled rx source", 32'(irq), 32'h1);
    clr_we = 1; clr_data = 32'h0000_0010;
    step();
    clr_we = 0; clr_data = 0;
    chk("R7 rx bit held while full", 32'(int_status[4]), 32'h1);

    for (int i = 1; i <= 64; i++) begin
      chk("R1 rx order", 32'(host_rx_data), 32'(rx_byte(i)));
      host_rx_pop = 1;
      step();
      host_rx_pop = 0;
      chk("R2 rx drain", fifo_level, lvl(64 - i, 0));
    end
    host_rx_pop = 1;
    step();
    host_rx_pop = 0;
    chk("R1 pop from empty ignored", fifo_level, lvl(0, 0));
    chk("R1 rx empty flag", 32'(rx_empty), 32'h1);
    clr_we = 1; clr_data = 32'h0000_0010;
    step();
    clr_we = 0; clr_data = 0;
    chk("R6 rx bit cleared", 32'(int_status[4]), 32'h0);
    chk("R8 irq drops after clear", 32'(irq), 32'h0);

    // transmit side
    for (int i = 0; i < 20; i++) begin
      host_tx_push = 1; host_tx_data = 8'(i) ^ 8'h5A;
      step();
    end
    host_tx_push = 0;
    chk("R2 tx fill", fifo_level, lvl(0, 20));
    clr_we = 1; clr_data = 32'h0000_1000;
    step();
    clr_we = 0; clr_data = 0;
    chk("R6 tx bit cleared above threshold", 32'(int_status[12]), 32'h0);
    for (int i = 0; i < 4; i++) begin
      chk("R1 tx order", 32'(eng_tx_data), 32'(8'(i) ^ 8'h5A));
      eng_tx_pop = 1;
      step();
      eng_tx_pop = 0;
      chk("R4 tx threshold timing", 32'(int_status[12]), 32'h0);
    end
    step();
    chk("R4 tx at 16 sets bit12", 32'(int_status[12]), 32'h1);
    chk("R2 tx fill after pops", fifo_level, lvl(0, 16));

    // transfer done
    xfer_done = 1;
    step();
    xfer_done = 0;
    chk("R5 done sets bit16", 32'(int_status[16]), 32'h1);
    clr_we = 1; clr_data = 32'h0000_0010;
    step();
    clr_we = 0; clr_data = 0;
    chk("R6 zero bits leave bit16", int_status, 32'h0001_1000);
    clr_we = 1; clr_data = 32'h0001_0000;
    step();
    clr_we = 0; clr_data = 0;
    chk("R6 bit16 cleared", int_status, 32'h0000_1000);
    irq_en = 32'h0001_1010;
    #1;
    chk("R8 tx source enabled", 32'(irq), 32'h1);
    irq_en = 32'h0001_0010;
    #1;
    chk("R8 tx source masked", 32'(irq), 32'h0);

    // flush
    for (int i = 0; i < 3; i++) begin
      eng_rx_push = 1; eng_rx_data = 8'(8'h30 + i);
      step();
    end
    eng_rx_push = 0;
    tx_flush = 1; host_tx_push = 1; host_tx_data = 8'h99; eng_tx_pop = 1;
    step();
    tx_flush = 0; host_tx_push = 0; eng_tx_pop = 0;
    chk("R9 tx flush wins, rx kept", fifo_level, lvl(3, 0));
    rx_flush = 1; eng_rx_push = 1; eng_rx_data = 8'h77; host_rx_pop = 1;
    step();
    rx_flush = 0; eng_rx_push = 0; host_rx_pop = 0;
    chk("R9 rx flush wins", fifo_level, lvl(0, 0));
    host_tx_push = 1; host_tx_data = 8'hC3;
    step();
    host_tx_push = 0;
    chk("R9 first byte after flush", 32'(eng_tx_data), 32'h0000_00C3);
    chk("R9 fill after flush", fifo_level, lvl(0, 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule